// File: doc/BRIEF.md
# SDRAM Refresh and Self-Refresh Controller

This block keeps a synchronous DRAM refreshed. An up-counting interval counter is compared with a programmable limit. When the two are equal, the block requests a refresh. It then drives an all-bank precharge, an auto-refresh command, a fixed run of wait cycles and a closing cycle onto the SDRAM command pins. While it owns the bus it raises a busy line toward the access arbiter. The arbiter may start an access only when that line is low.

The same block places the memory in self-refresh. This happens when both the refresh-enable and refresh-mode inputs are high: CKE goes low and the bus stays blocked. Self-refresh ends when refresh mode is cleared. The block then keeps the command pins silent for a programmable recovery window. After that, periodic auto-refresh continues if refresh is still enabled. A refresh that falls due inside the window waits for the window to end.

Self-refresh carries on through chip standby, through an NMI wake and through a manual reset. Only the power-on reset ends it. Software may preload the counter. Loading the limit minus one makes a refresh start almost at once.

Top module: `sdram_refresh_ctl`

## Requirements
- R1: With rfsh_en=1, rmode=0 and no standby in effect, cnt_q increments by one per cycle until it equals cmp, and then holds. A cnt_wr pulse loads cnt_wdata on the next edge, with priority over everything else.
- R2: In the cycle cnt_q equals cmp, auto mode is on and acc_busy is low, ref_busy goes high and the next cycle drives a precharge. After a write of value c, the precharge appears cmp-c+1 cycles after the write edge, which is 2 for c=cmp-1.
- R3: The refresh sequence is precharge-all, then refresh, then TRC_N wait cycles with NOP, then one closing NOP cycle, with ref_busy high throughout. Precharge-all is {cs_n,ras_n,cas_n,we_n}=0010 with a10=1. Refresh is 0001. NOP is 1111. cnt_q is 0 in the first idle cycle after the sequence.
- R4: While acc_busy is high, a due refresh does not start and ref_busy stays low. The precharge appears on the edge after acc_busy falls.
- R5: rfsh_en=1 with rmode=1 starts self-refresh with a precharge-all. The next cycle drives the refresh command with cke=0. After that, cke stays 0, the pins show NOP, ref_busy is 1 and cnt_q does not count.
- R6: Clearing rmode during self-refresh raises cke on the next edge. A blackout of rcv+1 cycles follows, with NOP on the pins and ref_busy high.
- R7: A refresh that falls due during the blackout is held. The first cycle after the blackout is idle with ref_busy high, and the cycle after it drives the precharge.
- R8: stby_req, nmi and mrst do not end self-refresh. A stby_req pulse freezes cnt_q, and the freeze lasts until nmi or mrst wakes the block.
- R9: When por_n is low, cke=1, the pins show NOP, a10=0, ref_busy=0 and cnt_q=0. After release, auto-refresh runs again and the first precharge appears cmp+1 cycles later.
- R10: With rfsh_en=0, cnt_q does not count and no command is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| rfsh_en | input | 1 | Refresh enable |
| rmode | input | 1 | Refresh mode, 1 selects self-refresh |
| rcv | input | 2 | Recovery blackout after self-refresh, rcv+1 cycles |
| cnt_wr | input | 1 | Load interval counter |
| cnt_wdata | input | CW | Counter load value |
| cmp | input | CW | Interval compare limit |
| stby_req | input | 1 | Chip enters standby |
| nmi | input | 1 | NMI wake from standby |
| mrst | input | 1 | Manual reset, also wakes from standby |
| acc_busy | input | 1 | An access is in progress |
| cnt_q | output | CW | Interval counter value |
| cke | output | 1 | SDRAM clock enable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| a10 | output | 1 | Address bit 10, all-bank select during precharge |
| ref_busy | output | 1 | Bus owned by refresh, arbiter must hold off |

## Verification
The two functions that can fall in the same cycle are the end of the recovery blackout and a refresh that came due while the blackout was running. To provoke this, the counter is loaded with the limit minus one during self-refresh. Self-refresh is then cleared under every recovery setting, so the match lands inside the blackout. The bench requires every blackout cycle to be silent. It then requires one idle cycle with busy asserted, and the precharge in the cycle after that. A second overlap pairs a due refresh with an access still in progress. There the bench checks that busy stays low until the access ends and that the precharge follows one edge later.

// File: rtl/sdram_refresh_ctl.sv
module sdram_refresh_ctl #(
  parameter int CW    = 8,
  parameter int TRC_N = 3
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          rfsh_en,
  input  logic          rmode,
  input  logic [1:0]    rcv,
  input  logic          cnt_wr,
  input  logic [CW-1:0] cnt_wdata,
  input  logic [CW-1:0] cmp,
  input  logic          stby_req,
  input  logic          nmi,
  input  logic          mrst,
  input  logic          acc_busy,
  output logic [CW-1:0] cnt_q,
  output logic          cke,
  output logic          cs_n,
  output logic          ras_n,
  output logic          cas_n,
  output logic          we_n,
  output logic          a10,
  output logic          ref_busy
);
  localparam int TW = (TRC_N > 1) ? $clog2(TRC_N) : 1;

  typedef enum logic [2:0] {S_IDLE, S_TP, S_TRR, S_TRC, S_TRE, S_SR, S_RCV} st_t;

  st_t           st;
  logic          sr_q;
  logic          stby_q;
  logic [TW-1:0] wait_q;
  logic [1:0]    rq;

  wire auto_on = rfsh_en && !rmode;
  wire sr_go   = rfsh_en && rmode;
  wire req     = auto_on && (cnt_q == cmp);
  wire go      = (st == S_IDLE) && !acc_busy && (sr_go || req);
  wire cnt_inc = auto_on && !stby_q && (cnt_q != cmp) && (st != S_SR);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cnt_q <= '0;
    end else if (cnt_wr) begin
      cnt_q <= cnt_wdata;
    end else if (st == S_TRE) begin
      cnt_q <= '0;
    end else if (cnt_inc) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)               stby_q <= 1'b0;
    else if (nmi || mrst)     stby_q <= 1'b0;
    else if (stby_req)        stby_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      st     <= S_IDLE;
      sr_q   <= 1'b0;
      wait_q <= '0;
      rq     <= '0;
    end else begin
      case (st)
        S_IDLE: if (go) begin
          st   <= S_TP;
          sr_q <= sr_go;
        end
        S_TP:  st <= S_TRR;
        S_TRR: begin
          if (sr_q) st <= S_SR;
          else begin
            st     <= S_TRC;
            wait_q <= TW'(TRC_N - 1);
          end
        end
        S_TRC: begin
          if (wait_q == '0) st <= S_TRE;
          else wait_q <= wait_q - 1'b1;
        end
        S_TRE: st <= S_IDLE;
        S_SR: if (!rmode) begin
          st <= S_RCV;
          rq <= rcv;
        end
        S_RCV: begin
          if (rq == 2'd0) st <= S_IDLE;
          else rq <= rq - 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  wire pre_c = (st == S_TP);
  wire ref_c = (st == S_TRR);

  assign cs_n     = !(pre_c || ref_c);
  assign ras_n    = !(pre_c || ref_c);
  assign cas_n    = !ref_c;
  assign we_n     = !pre_c;
  assign a10      = pre_c;
  assign cke      = !((st == S_SR) || (ref_c && sr_q));
  assign ref_busy = (st != S_IDLE) || go;

  p_wr_load_r1: assert property (@(posedge clk) disable iff (!por_n)
    cnt_wr |=> (cnt_q == $past(cnt_wdata)));

  p_pre_all_r3: assert property (@(posedge clk) disable iff (!por_n)
    (!cs_n && !ras_n && cas_n && !we_n) |-> (a10 && ref_busy));

  p_pre_then_ref_r3: assert property (@(posedge clk) disable iff (!por_n)
    (!cs_n && !ras_n && cas_n && !we_n) |=> (!cs_n && !ras_n && !cas_n && we_n));

  p_sr_entry_cmd_r5: assert property (@(posedge clk) disable iff (!por_n)
    $fell(cke) |-> (!cs_n && !ras_n && !cas_n && we_n));

  p_sr_busy_r5: assert property (@(posedge clk) disable iff (!por_n)
    !cke |-> ref_busy);

  p_exit_quiet_r6: assert property (@(posedge clk) disable iff (!por_n)
    $rose(cke) |-> (cs_n && ref_busy));

  p_exit_next_quiet_r6: assert property (@(posedge clk) disable iff (!por_n)
    $rose(cke) |=> cs_n);
endmodule

// File: tb/tb_sdram_refresh_ctl.sv
module tb_sdram_refresh_ctl;
  localparam int CW = 8;
  localparam int TRC_N = 3;

  logic clk = 0;
  logic por_n = 0, rfsh_en = 0, rmode = 0, cnt_wr = 0;
  logic stby_req = 0, nmi = 0, mrst = 0, acc_busy = 0;
  logic [1:0] rcv = 0;
  logic [CW-1:0] cnt_wdata = 0, cmp = 0;
  logic [CW-1:0] cnt_q;
  logic cke, cs_n, ras_n, cas_n, we_n, a10, ref_busy;

  int errs = 0, checks = 0, cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sdram_refresh_ctl #(.CW(CW), .TRC_N(TRC_N)) dut (
    .clk(clk), .por_n(por_n), .rfsh_en(rfsh_en), .rmode(rmode), .rcv(rcv),
    .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .cmp(cmp), .stby_req(stby_req),
    .nmi(nmi), .mrst(mrst), .acc_busy(acc_busy), .cnt_q(cnt_q), .cke(cke),
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .a10(a10),
    .ref_busy(ref_busy));

  wire [3:0] cmd = {cs_n, ras_n, cas_n, we_n};
  localparam logic [3:0] PRE = 4'b0010, REF = 4'b0001, NOP = 4'b1111;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wait_pre(input int exp, input string tag);
    int k = 0;
    for (int i = 1; i <= 60; i++) begin
      step();
      if (cmd == PRE) begin k = i; break; end
    end
    chk(k == exp, tag, k, exp);
    chk(a10 == 1 && ref_busy == 1, "R3 precharge a10/busy", {a10, ref_busy}, 3);
  endtask

  task automatic tail();
    step();
    chk(cmd == REF && cke == 1, "R3 refresh cmd", {cke, cmd}, {1'b1, REF});
    for (int i = 0; i < TRC_N; i++) begin
      step();
      chk(cmd == NOP && ref_busy, "R3 trc wait", {ref_busy, cmd}, {1'b1, NOP});
    end
    step();
    chk(cmd == NOP && ref_busy, "R3 tre", {ref_busy, cmd}, {1'b1, NOP});
    step();
    chk(!ref_busy && cnt_q == 0 && cmd == NOP, "R3 end idle cnt", {ref_busy, cnt_q}, 0);
  endtask

  initial begin
    int v;
    step(); step();
    chk(cke && cmd == NOP && !a10 && !ref_busy && cnt_q == 0, "R9 reset state",
        {cke, cmd, a10, ref_busy, cnt_q}, {1'b1, NOP, 2'b00, 8'd0});
    por_n = 1; cmp = 3;
    for (int i = 0; i < 10; i++) begin
      step();
      chk(cnt_q == 0 && cmd == NOP && !ref_busy, "R10 disabled", cnt_q, 0);
    end

    rfsh_en = 1;
    for (int cm = 2; cm <= 6; cm++) begin
      for (int c = 0; c < cm; c++) begin
        cmp = CW'(cm); cnt_wdata = CW'(c); cnt_wr = 1;
        step(); cnt_wr = 0;
        chk(cnt_q == CW'(c), "R1 counter load", cnt_q, c);
        wait_pre(cm - c + 1, "R2 delay to precharge");
        tail();
      end
    end

    cmp = 4; cnt_wdata = 3; cnt_wr = 1; acc_busy = 1;
    step(); cnt_wr = 0;
    for (int i = 0; i < 5; i++) begin
      step();
      chk(cmd == NOP && !ref_busy, "R4 held by access", {ref_busy, cmd}, NOP);
    end
    chk(cnt_q == 4, "R1 holds at cmp", cnt_q, 4);
    acc_busy = 0; #1;
    chk(ref_busy, "R4 busy on access end", ref_busy, 1);
    wait_pre(1, "R4 precharge after access");
    tail();

    cmp = 20; cnt_wdata = 0; cnt_wr = 1;
    step(); cnt_wr = 0; stby_req = 1;
    step(); stby_req = 0; v = cnt_q;
    for (int i = 0; i < 5; i++) step();
    chk(cnt_q == CW'(v), "R8 standby freeze", cnt_q, v);
    nmi = 1; step(); nmi = 0;
    chk(cnt_q == CW'(v), "R8 nmi wake edge", cnt_q, v);
    step();
    chk(cnt_q == CW'(v + 1), "R8 counting after nmi", cnt_q, v + 1);
    stby_req = 1; step(); stby_req = 0; v = cnt_q;
    step(); step();
    chk(cnt_q == CW'(v), "R8 standby freeze 2", cnt_q, v);
    mrst = 1; step(); mrst = 0; step();
    chk(cnt_q == CW'(v + 1), "R8 counting after mrst", cnt_q, v + 1);

    for (int r = 0; r < 4; r++) begin
      rmode = 1;
      step();
      chk(cmd == PRE && a10 && cke, "R5 entry precharge", {cke, cmd}, {1'b1, PRE});
      step();
      chk(cmd == REF && !cke, "R5 entry cmd cke low", {cke, cmd}, {1'b0, REF});
      step();
      chk(cmd == NOP && !cke && ref_busy, "R5 in self-refresh", {cke, cmd}, {1'b0, NOP});
      stby_req = 1; step(); stby_req = 0;
      chk(!cke && cmd == NOP, "R8 standby keeps sr", cke, 0);
      nmi = 1; step(); nmi = 0;
      chk(!cke && cmd == NOP, "R8 nmi keeps sr", cke, 0);
      mrst = 1; step(); mrst = 0;
      chk(!cke && cmd == NOP, "R8 mrst keeps sr", cke, 0);
      cnt_wdata = 19; cnt_wr = 1; step(); cnt_wr = 0;
      step(); step();
      chk(cnt_q == 19 && !cke, "R5 no count in sr", cnt_q, 19);
      rmode = 0; rcv = 2'(r);
      for (int i = 0; i <= r; i++) begin
        step();
        chk(cke && cmd == NOP && ref_busy, "R6 blackout", {cke, ref_busy, cmd}, {2'b11, NOP});
      end
      step();
      chk(cmd == NOP && ref_busy && cke, "R7 held request idle", {ref_busy, cmd}, {1'b1, NOP});
      wait_pre(1, "R7 precharge after blackout");
      tail();
    end

    rmode = 1; step(); step(); step();
    chk(!cke, "R5 sr before por", cke, 0);
    por_n = 0; rmode = 0; cmp = 3; #1;
    chk(cke && cmd == NOP && !ref_busy && cnt_q == 0 && !a10, "R9 por ends sr",
        {cke, cmd, ref_busy, cnt_q}, {1'b1, NOP, 9'd0});
    step(); por_n = 1;
    wait_pre(4, "R9 refresh resumes after por");
    tail();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      errs++; checks++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule